// File: doc/BRIEF.md
# Overlapped Burst Read Sequencer

This block sequences block reads on a synchronous bus that is 64 bits wide and carries 32-bit words. A start command supplies a base word address, a word count and a block-size choice of 4 or 16 words. The sequencer splits the transfer into block transactions that run back to back.

Each transaction has three parts. It spends one cycle presenting the block address. It then waits out the initial memory latency. After that it streams every four-word group as two 64-bit beats followed by two idle cycles. The read of the next group is hidden under the current group's beats and idle cycles, so later groups add no extra wait. With the default latency of 40 cycles, a 4-word block costs 45 cycles and a 16-word block costs 57 cycles.

No memory array is modelled. Each beat carries address-tagged data, where each 32-bit word equals its own word address. At the end, the block gives a one-cycle completion strobe and the total cycle count.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, busy, addr_valid, beat_valid, done and err are low and cycle_total is 0.
- R2: Each block transaction begins with exactly one cycle of addr_valid, with addr_out equal to base_addr plus the number of words already transferred.
- R3: The first beat of a block appears FIRST_LAT+1 cycles after its address cycle (41 by default), with no beat in between.
- R4: Each four-word group is two beat_valid cycles in a row. beat_idx is the word index of the lower word (0, 2, 4, ...). beat_data[31:0] is base_addr+beat_idx and beat_data[63:32] is base_addr+beat_idx+1.
- R5: Exactly two idle cycles follow each group. Inside a 16-word block, the next group's first beat comes right after them with no further wait.
- R6: With blk16=0 a block takes 45 cycles, and with blk16=1 it takes 57 cycles. The next block's address cycle follows the previous block's last idle cycle directly, and busy stays high throughout.
- R7: done is high for exactly one cycle, directly after the final idle cycle. In that cycle cycle_total equals the number of active cycles: 2880 for 256 words with blk16=0, and 912 with blk16=1. The value holds until the next accepted start.
- R8: blk16, base_addr and word_count are sampled only in the cycle a start is accepted. Later changes do not affect the transfer in progress.
- R9: A start whose word_count is zero, or is not a multiple of the block size (4 or 16), raises err for one cycle in the next cycle. No transfer follows, busy stays low and cycle_total is unchanged.
- R10: A start asserted while busy is high, including the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| base_addr | input | 32 | Starting word address |
| word_count | input | CNT_W | Number of 32-bit words to read |
| blk16 | input | 1 | 1 selects 16-word blocks, 0 selects 4-word blocks |
| busy | output | 1 | A transfer is in progress (address through done cycle) |
| addr_valid | output | 1 | Address cycle of a block transaction |
| addr_out | output | 32 | Block word address, valid with addr_valid |
| beat_valid | output | 1 | A 64-bit data beat is on beat_data |
| beat_data | output | 64 | Two words, lower word in bits 31:0 |
| beat_idx | output | CNT_W | Word index of the lower word of the beat |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle strobe for a rejected command |
| cycle_total | output | 32 | Active cycles used by the last transfer |

## Verification
A latency counter that is off by one would shift every beat, and the per-cycle comparison would catch it at the first beat of each block. Adding a fetch wait between groups would make 16-word blocks longer than 57 cycles. A missing idle cycle would let two groups run together. A count that wraps wrongly would stop one block early or run one block too many. The bench changes blk16, base_addr and word_count right after a start, and pulses start in the middle of a transfer and during the done cycle, so a design that re-samples its inputs would change its addresses or block length. Rejected counts (zero, 6, 20, and 8 with 16-word blocks) must produce err with no address cycle and an unchanged cycle_total.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int CNT_W      = 16,
  parameter int FIRST_LAT  = 40,
  parameter int IDLE_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      base_addr,
  input  logic [CNT_W-1:0] word_count,
  input  logic             blk16,
  output logic             busy,
  output logic             addr_valid,
  output logic [31:0]      addr_out,
  output logic             beat_valid,
  output logic [63:0]      beat_data,
  output logic [CNT_W-1:0] beat_idx,
  output logic             done,
  output logic             err,
  output logic [31:0]      cycle_total
);
  localparam int BEATS = 2;
  localparam int SLOTS = BEATS + IDLE_SLOTS;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int LW    = $clog2(FIRST_LAT + 1);
  localparam int BIG_GROUPS = 4;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WAIT, S_XFER, S_DONE} st_t;

  st_t             st;
  logic            big;
  logic [31:0]     base;
  logic [CNT_W-1:0] total, widx;
  logic [LW-1:0]   lat;
  logic [SW-1:0]   slot;
  logic [1:0]      grp;
  logic [31:0]     cyc;
  logic            err_q;

  wire count_ok = (word_count != '0) &&
                  (blk16 ? (word_count[3:0] == 4'd0) : (word_count[1:0] == 2'd0));
  wire [1:0] last_grp  = big ? 2'(BIG_GROUPS - 1) : 2'd0;
  wire       slot_last = (slot == SW'(SLOTS - 1));
  wire       in_beat   = (slot < SW'(BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      big   <= 1'b0;
      base  <= '0;
      total <= '0;
      widx  <= '0;
      lat   <= '0;
      slot  <= '0;
      grp   <= '0;
      cyc   <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (count_ok) begin
            st    <= S_ADDR;
            big   <= blk16;
            base  <= base_addr;
            total <= word_count;
            widx  <= '0;
            cyc   <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_ADDR: begin
          cyc  <= cyc + 32'd1;
          lat  <= '0;
          grp  <= '0;
          slot <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          cyc <= cyc + 32'd1;
          lat <= lat + LW'(1);
          if (lat == LW'(FIRST_LAT - 1)) st <= S_XFER;
        end
        S_XFER: begin
          cyc  <= cyc + 32'd1;
          slot <= slot + SW'(1);
          if (in_beat) widx <= widx + CNT_W'(2);
          if (slot_last) begin
            slot <= '0;
            if (grp == last_grp) st <= (widx == total) ? S_DONE : S_ADDR;
            else grp <= grp + 2'd1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [31:0] lo_word = base + 32'(widx);

  assign busy        = (st != S_IDLE);
  assign addr_valid  = (st == S_ADDR);
  assign addr_out    = lo_word;
  assign beat_valid  = (st == S_XFER) && in_beat;
  assign beat_data   = {lo_word + 32'd1, lo_word};
  assign beat_idx    = widx;
  assign done        = (st == S_DONE);
  assign err         = err_q;
  assign cycle_total = cyc;

  a_r2_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);
  a_r3_no_beat_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !beat_valid);
  a_r4_beat_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |=> beat_valid);
  a_r5_pair_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |=> !beat_valid);
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> (beat_idx == $past(beat_idx) + CNT_W'(2)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  a_r7_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(cycle_total));
endmodule

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;
  localparam int CNT_W = 16;
  localparam int LAT   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [CNT_W-1:0] word_count = '0;
  logic blk16 = 1'b0;
  logic busy, addr_valid, beat_valid, done, err;
  logic [31:0] addr_out, cycle_total;
  logic [63:0] beat_data;
  logic [CNT_W-1:0] beat_idx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_read_seq #(.CNT_W(CNT_W), .FIRST_LAT(LAT), .IDLE_SLOTS(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .blk16(blk16), .busy(busy), .addr_valid(addr_valid),
    .addr_out(addr_out), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_idx(beat_idx), .done(done), .err(err), .cycle_total(cycle_total));

  typedef struct packed {
    logic             av;
    logic [31:0]      a;
    logic             bv;
    logic [CNT_W-1:0] ix;
    logic [63:0]      d;
    logic             dn;
  } ent_t;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] b, input int n, input bit big,
                     input int inject_at, input int exp_cycles);
    ent_t q[$];
    int w = 0;
    int gpb = big ? 4 : 1;
    int addr_cyc = -1;
    int first_beat_seen = 0;
    while (w < n) begin
      ent_t e = '0;
      e.av = 1'b1; e.a = b + 32'(w);
      q.push_back(e);
      for (int i = 0; i < LAT; i++) q.push_back(ent_t'(0));
      for (int g = 0; g < gpb; g++) begin
        for (int k = 0; k < 2; k++) begin
          ent_t bt = '0;
          bt.bv = 1'b1; bt.ix = CNT_W'(w);
          bt.d = {b + 32'(w) + 32'd1, b + 32'(w)};
          q.push_back(bt);
          w += 2;
        end
        q.push_back(ent_t'(0));
        q.push_back(ent_t'(0));
      end
    end
    begin
      ent_t de = '0;
      de.dn = 1'b1;
      q.push_back(de);
    end
    @(negedge clk);
    start = 1'b1; base_addr = b; word_count = CNT_W'(n); blk16 = big;
    @(negedge clk);
    // R8: change every command input right after acceptance
    start = 1'b0; base_addr = 32'hDEAD_0000; word_count = CNT_W'(3); blk16 = ~big;
    for (int i = 0; i < q.size(); i++) begin
      ent_t e = q[i];
      bit last = (i == q.size() - 1);
      chk(busy === 1'b1, "R6", "busy", busy, 1);
      chk(addr_valid === e.av, "R2", "addr_valid", addr_valid, e.av);
      if (e.av) begin
        chk(addr_out === e.a, "R2", "addr_out", addr_out, e.a);
        addr_cyc = i; first_beat_seen = 0;
      end
      chk(beat_valid === e.bv, "R5", "beat_valid", beat_valid, e.bv);
      if (beat_valid && !first_beat_seen && addr_cyc >= 0) begin
        chk(i - addr_cyc == LAT + 1, "R3", "first beat distance", i - addr_cyc, LAT + 1);
        first_beat_seen = 1;
      end
      if (e.bv) begin
        chk(beat_idx === e.ix, "R4", "beat_idx", beat_idx, e.ix);
        chk(beat_data === e.d, "R4", "beat_data", beat_data, e.d);
      end
      chk(done === e.dn, "R7", "done", done, e.dn);
      chk(err === 1'b0, "R9", "err during run", err, 0);
      if (last) begin
        chk(cycle_total == 32'(q.size() - 1), "R7", "cycle_total", cycle_total, q.size() - 1);
        if (exp_cycles > 0)
          chk(cycle_total == 32'(exp_cycles), "R6", "block cycle sum", cycle_total, exp_cycles);
      end
      // R10: start while busy (mid-run or in the done cycle) must be ignored
      start = (i == inject_at) || (last && inject_at >= 0);
      if (start) begin
        base_addr = 32'h0BAD_0000; word_count = CNT_W'(16); blk16 = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy === 1'b0, "R10", "busy after done", busy, 0);
    chk(addr_valid === 1'b0, "R10", "no restart", addr_valid, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R10", "still idle", busy, 0);
  endtask

  task automatic reject(input int n, input bit big);
    logic [31:0] prev;
    @(negedge clk);
    prev = cycle_total;
    start = 1'b1; base_addr = 32'h5000; word_count = CNT_W'(n); blk16 = big;
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1, "R9", "err raised", err, 1);
    chk(busy === 1'b0, "R9", "busy on reject", busy, 0);
    @(negedge clk);
    chk(err === 1'b0, "R9", "err one cycle", err, 0);
    chk(addr_valid === 1'b0, "R9", "no address cycle", addr_valid, 0);
    chk(cycle_total == prev, "R9", "cycle_total kept", cycle_total, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy", busy, 0);
    chk(addr_valid === 1'b0 && beat_valid === 1'b0, "R1", "strobes", addr_valid | beat_valid, 0);
    chk(done === 1'b0 && err === 1'b0, "R1", "done/err", done | err, 0);
    chk(cycle_total == 32'd0, "R1", "cycle_total", cycle_total, 0);

    run(32'h0000_0040, 4, 1'b0, -1, 45);
    run(32'h0000_0080, 16, 1'b1, -1, 57);
    run(32'h0000_1000, 256, 1'b0, -1, 2880);
    run(32'h0000_2000, 256, 1'b1, -1, 912);
    run(32'h0000_0100, 12, 1'b0, 10, 135);
    run(32'hFFFF_FFF0, 32, 1'b1, 60, 114);
    run(32'h0000_0300, 16, 1'b0, 100, 180);

    reject(0, 1'b0);
    reject(6, 1'b0);
    reject(20, 1'b1);
    reject(8, 1'b1);

    run(32'h0000_0500, 8, 1'b0, -1, 90);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule